// File: doc/BRIEF.md
# Standard-Definition Raster Timing Generator

The block produces the horizontal and vertical raster timing for standard-definition composite video, sampled at a 13.5 MHz pixel rate. It keeps a pixel counter and a line counter. From those it derives an active-low horizontal sync, an active-low vertical sync, an active-picture flag and a field-parity flag.

One input selects between the 525-line system and the 625-line system. A second input selects interlaced scan or the fixed-length progressive scan. A pixel-rate enable lets the block run from a faster clock: the state moves only on cycles where that enable is high.

All geometry is parameterised, and the defaults give the standard values. A line holds 720 active pixels and then the front porch, which is 14 pixels for 525 and 20 for 625. The sync pulse of 64 pixels follows, then a back porch of 60 pixels. A field holds the active lines and then a gap before vertical sync, which is 3 lines for 525 and 2 for 625. Vertical sync of 3 lines follows, then blanking up to the field total. In progressive scan the field total is fixed. In interlaced scan the two fields of a frame differ by one line.

Top module: `sd_raster_gen`

## Requirements
- R1: While reset is asserted and directly after it is released, h_cnt and v_cnt are 0, field is 0, hsync_n and vsync_n are 1, and active is 1.
- R2: On a clock edge where pix_en is low, no output changes.
- R3: With pix_en high, h_cnt counts up by one per clock edge. It returns to 0 after 857 when sys_625=0 (858 pixels per line) and after 863 when sys_625=1 (864 pixels per line). v_cnt advances on that same edge.
- R4: hsync_n is 0 exactly while h_cnt is in 734..797 for sys_625=0, and in 740..803 for sys_625=1. It changes on the same edge as h_cnt.
- R5: With interlace=0, v_cnt returns to 0 after line 261 (sys_625=0) or after line 311 (sys_625=1). field stays 0.
- R6: With interlace=1, field toggles at every wrap of v_cnt. The field with field=0 has 262 lines for 525 and 312 lines for 625. The field with field=1 has one line more, so a frame totals 525 or 625 lines.
- R7: vsync_n is 0 exactly while v_cnt is in 243..245 (sys_625=0) or in 290..292 (sys_625=1). This holds in every field and in both scan types.
- R8: active is 1 exactly while h_cnt < 720 and v_cnt is below 240 (sys_625=0) or below 288 (sys_625=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sys_625 | input | 1 | 0 selects the 525-line system, 1 selects the 625-line system |
| interlace | input | 1 | 1 selects interlaced scan, 0 selects progressive scan |
| pix_en | input | 1 | Pixel-rate enable; the state advances only while it is high |
| h_cnt | output | CW | Pixel position within the line |
| v_cnt | output | CW | Line position within the field |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | High inside the active picture |
| field | output | 1 | Field parity |

## Verification
Every output is a register that is loaded from next-state logic. Each output therefore takes its new value on the same rising edge on which pix_en is sampled high, with no extra cycle of latency, and holds when pix_en was low. The bench drives pix_en and samples all outputs on the falling edge. Its reference model is advanced one step for each edge on which it drove the enable high, so each comparison falls half a cycle after the edge that is due to produce it. A scaled-geometry instance walks whole frames, including interlaced field pairs and gated enables. The default instance checks the full 858-pixel and 864-pixel lines.

// File: rtl/sd_raster_pkg.sv
package sd_raster_pkg;

   localparam int unsigned SD_CW_DEFAULT = 10;

   typedef enum logic {
      SYS_525 = 1'b0,
      SYS_625 = 1'b1
   } sd_sys_e;

endpackage

// File: rtl/sd_line_timer.sv
module sd_line_timer #(
   parameter int CW       = 10,
   parameter int ACT_PIX  = 720,
   parameter int FP_A     = 14,
   parameter int FP_B     = 20,
   parameter int SYNC_PIX = 64,
   parameter int BP_PIX   = 60
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_en,
   input  logic          sel_b,
   output logic [CW-1:0] h_q,
   output logic          line_last,
   output logic          hsync_n,
   output logic          h_act
);

   localparam int TOT_A_I = ACT_PIX + FP_A + SYNC_PIX + BP_PIX;
   localparam int TOT_B_I = ACT_PIX + FP_B + SYNC_PIX + BP_PIX;
   localparam logic [CW-1:0] TOT_A = CW'(TOT_A_I);
   localparam logic [CW-1:0] TOT_B = CW'(TOT_B_I);
   localparam logic [CW-1:0] HSB_A = CW'(ACT_PIX + FP_A);
   localparam logic [CW-1:0] HSB_B = CW'(ACT_PIX + FP_B);
   localparam logic [CW-1:0] HSE_A = CW'(ACT_PIX + FP_A + SYNC_PIX);
   localparam logic [CW-1:0] HSE_B = CW'(ACT_PIX + FP_B + SYNC_PIX);
   localparam logic [CW-1:0] ACT_C = CW'(ACT_PIX);

   generate
      if (TOT_A_I > (2 ** CW) || TOT_B_I > (2 ** CW)) begin : g_bad_width
         $error("line total does not fit the counter width");
      end
      if (ACT_PIX < 1 || SYNC_PIX < 1 || FP_A < 1 || FP_B < 1) begin : g_bad_geom
         $error("horizontal geometry segments must be non-empty");
      end
   endgenerate

   logic [CW-1:0] tot;
   logic [CW-1:0] hs_beg;
   logic [CW-1:0] hs_end;
   logic [CW-1:0] h_nxt;

   always_comb begin
      tot       = sel_b ? TOT_B : TOT_A;
      hs_beg    = sel_b ? HSB_B : HSB_A;
      hs_end    = sel_b ? HSE_B : HSE_A;
      line_last = (h_q >= tot - 1'b1);
      h_nxt     = line_last ? '0 : h_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q     <= '0;
         hsync_n <= 1'b1;
         h_act   <= 1'b1;
      end else if (pix_en) begin
         h_q     <= h_nxt;
         hsync_n <= !((h_nxt >= hs_beg) && (h_nxt < hs_end));
         h_act   <= (h_nxt < ACT_C);
      end
   end

   // R3
   h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && h_q == tot - 1'b1) |=> (h_q == '0));

   // R2
   h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> ($stable(h_q) && $stable(hsync_n) && $stable(h_act)));

   // R4
   hs_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hsync_n |-> !h_act);

endmodule

// File: rtl/sd_field_timer.sv
module sd_field_timer #(
   parameter int CW       = 10,
   parameter int ACT_LN_A = 240,
   parameter int ACT_LN_B = 288,
   parameter int GAP_A    = 3,
   parameter int GAP_B    = 2,
   parameter int VS_LEN   = 3,
   parameter int PROG_A   = 262,
   parameter int PROG_B   = 312
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          sel_b,
   input  logic          interlace,
   output logic [CW-1:0] v_q,
   output logic          field_q,
   output logic          vsync_n,
   output logic          v_act
);

   localparam logic [CW-1:0] PROG_A_C = CW'(PROG_A);
   localparam logic [CW-1:0] PROG_B_C = CW'(PROG_B);
   localparam logic [CW-1:0] ACT_A_C  = CW'(ACT_LN_A);
   localparam logic [CW-1:0] ACT_B_C  = CW'(ACT_LN_B);
   localparam logic [CW-1:0] VSB_A    = CW'(ACT_LN_A + GAP_A);
   localparam logic [CW-1:0] VSB_B    = CW'(ACT_LN_B + GAP_B);
   localparam logic [CW-1:0] VSE_A    = CW'(ACT_LN_A + GAP_A + VS_LEN);
   localparam logic [CW-1:0] VSE_B    = CW'(ACT_LN_B + GAP_B + VS_LEN);

   generate
      if (PROG_A + 1 > (2 ** CW) || PROG_B + 1 > (2 ** CW)) begin : g_bad_width
         $error("field total does not fit the counter width");
      end
      if (VS_LEN < 1 || GAP_A < 1 || GAP_B < 1) begin : g_bad_sync
         $error("vertical sync and its leading gap must be non-empty");
      end
      if (ACT_LN_A + GAP_A + VS_LEN >= PROG_A ||
          ACT_LN_B + GAP_B + VS_LEN >= PROG_B) begin : g_bad_geom
         $error("vertical sync must end before the field total");
      end
   endgenerate

   logic [CW-1:0] tot;
   logic [CW-1:0] act_lim;
   logic [CW-1:0] vs_beg;
   logic [CW-1:0] vs_end;
   logic          last;
   logic [CW-1:0] v_nxt;
   logic          f_nxt;

   always_comb begin
      tot     = (sel_b ? PROG_B_C : PROG_A_C)
              + {{(CW-1){1'b0}}, (interlace & field_q)};
      act_lim = sel_b ? ACT_B_C : ACT_A_C;
      vs_beg  = sel_b ? VSB_B : VSB_A;
      vs_end  = sel_b ? VSE_B : VSE_A;
      last    = (v_q >= tot - 1'b1);
      v_nxt   = last ? '0 : v_q + 1'b1;
      f_nxt   = last ? (interlace & ~field_q) : field_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q     <= '0;
         field_q <= 1'b0;
         vsync_n <= 1'b1;
         v_act   <= 1'b1;
      end else if (step) begin
         v_q     <= v_nxt;
         field_q <= f_nxt;
         vsync_n <= !((v_nxt >= vs_beg) && (v_nxt < vs_end));
         v_act   <= (v_nxt < act_lim);
      end
   end

   // R6
   field_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && interlace && v_q == tot - 1'b1) |=> (field_q != $past(field_q)));

   // R5
   prog_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !interlace && last) |=> (!field_q && v_q == '0));

   // R7
   vs_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync_n |-> !v_act);

   // R2
   v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(v_q) && $stable(field_q) && $stable(vsync_n)));

endmodule

// File: rtl/sd_raster_gen.sv
module sd_raster_gen
   import sd_raster_pkg::*;
#(
   parameter int CW          = SD_CW_DEFAULT,
   parameter int ACT_PIX     = 720,
   parameter int FP_525      = 14,
   parameter int FP_625      = 20,
   parameter int SYNC_PIX    = 64,
   parameter int BP_PIX      = 60,
   parameter int ACT_LN_525  = 240,
   parameter int ACT_LN_625  = 288,
   parameter int VS_GAP_525  = 3,
   parameter int VS_GAP_625  = 2,
   parameter int VS_LEN      = 3,
   parameter int PROG_LN_525 = 262,
   parameter int PROG_LN_625 = 312
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sys_625,
   input  logic          interlace,
   input  logic          pix_en,
   output logic [CW-1:0] h_cnt,
   output logic [CW-1:0] v_cnt,
   output logic          hsync_n,
   output logic          vsync_n,
   output logic          active,
   output logic          field
);

   localparam logic [CW-1:0] ACT_PIX_C = CW'(ACT_PIX);
   localparam logic [CW-1:0] ACT_525_C = CW'(ACT_LN_525);
   localparam logic [CW-1:0] ACT_625_C = CW'(ACT_LN_625);

   sd_sys_e sys;
   logic    sel_b;
   logic    line_last;
   logic    h_act;
   logic    v_act;

   assign sys   = sd_sys_e'(sys_625);
   assign sel_b = (sys == SYS_625);

   sd_line_timer #(
      .CW       (CW),
      .ACT_PIX  (ACT_PIX),
      .FP_A     (FP_525),
      .FP_B     (FP_625),
      .SYNC_PIX (SYNC_PIX),
      .BP_PIX   (BP_PIX)
   ) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_en    (pix_en),
      .sel_b     (sel_b),
      .h_q       (h_cnt),
      .line_last (line_last),
      .hsync_n   (hsync_n),
      .h_act     (h_act)
   );

   sd_field_timer #(
      .CW       (CW),
      .ACT_LN_A (ACT_LN_525),
      .ACT_LN_B (ACT_LN_625),
      .GAP_A    (VS_GAP_525),
      .GAP_B    (VS_GAP_625),
      .VS_LEN   (VS_LEN),
      .PROG_A   (PROG_LN_525),
      .PROG_B   (PROG_LN_625)
   ) u_field (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (pix_en & line_last),
      .sel_b     (sel_b),
      .interlace (interlace),
      .v_q       (v_cnt),
      .field_q   (field),
      .vsync_n   (vsync_n),
      .v_act     (v_act)
   );

   assign active = h_act & v_act;

   // R8
   active_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> ((h_cnt < ACT_PIX_C) && (v_cnt < (sel_b ? ACT_625_C : ACT_525_C))));

   // R3
   line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && line_last) |=> (h_cnt == '0 && v_cnt != $past(v_cnt)));

endmodule

// File: tb/sim_sd_raster_gen.sv
module sim_sd_raster_gen;

   localparam int CW = 10;

   // scaled geometry for the frame-level instance
   localparam int S_ACT = 16, S_FP5 = 2, S_FP6 = 4, S_SYN = 6, S_BP = 4;
   localparam int S_AL5 = 10, S_AL6 = 12, S_G5 = 3, S_G6 = 2, S_VL = 3;
   localparam int S_PR5 = 18, S_PR6 = 20;

   // default geometry
   localparam int D_ACT = 720, D_FP5 = 14, D_FP6 = 20, D_SYN = 64, D_BP = 60;
   localparam int D_AL5 = 240, D_AL6 = 288, D_G5 = 3, D_G6 = 2, D_VL = 3;
   localparam int D_PR5 = 262, D_PR6 = 312;

   // vector: {sys_625, interlace, gated enable, cycle count[15:0]}
   localparam int NVEC = 6;
   localparam logic [18:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 1'b0, 16'd1100},
      {1'b1, 1'b0, 1'b0, 16'd1300},
      {1'b0, 1'b1, 1'b0, 16'd2200},
      {1'b1, 1'b1, 1'b1, 16'd7400},
      {1'b0, 1'b1, 1'b1, 16'd6300},
      {1'b1, 1'b0, 1'b1, 16'd3600}
   };

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic sys_625 = 1'b0;
   logic interlace = 1'b0;
   logic pix_en = 1'b0;

   logic [CW-1:0] h0, v0, h1, v1;
   logic hs0, vs0, ac0, f0, hs1, vs1, ac1, f1;

   int tests = 0;
   int fails = 0;
   int mh = 0, mv = 0, mf = 0;

   sd_raster_gen u0 (
      .clk(clk), .rst_n(rst_n), .sys_625(sys_625), .interlace(interlace),
      .pix_en(pix_en), .h_cnt(h0), .v_cnt(v0), .hsync_n(hs0),
      .vsync_n(vs0), .active(ac0), .field(f0)
   );

   sd_raster_gen #(
      .CW(CW), .ACT_PIX(S_ACT), .FP_525(S_FP5), .FP_625(S_FP6),
      .SYNC_PIX(S_SYN), .BP_PIX(S_BP), .ACT_LN_525(S_AL5), .ACT_LN_625(S_AL6),
      .VS_GAP_525(S_G5), .VS_GAP_625(S_G6), .VS_LEN(S_VL),
      .PROG_LN_525(S_PR5), .PROG_LN_625(S_PR6)
   ) u1 (
      .clk(clk), .rst_n(rst_n), .sys_625(sys_625), .interlace(interlace),
      .pix_en(pix_en), .h_cnt(h1), .v_cnt(v1), .hsync_n(hs1),
      .vsync_n(vs1), .active(ac1), .field(f1)
   );

   function automatic int fp_of(bit big, bit s);
      if (big) return s ? D_FP6 : D_FP5;
      return s ? S_FP6 : S_FP5;
   endfunction

   function automatic int act_pix(bit big);
      return big ? D_ACT : S_ACT;
   endfunction

   function automatic int syn_pix(bit big);
      return big ? D_SYN : S_SYN;
   endfunction

   function automatic int htot(bit big, bit s);
      return act_pix(big) + fp_of(big, s) + syn_pix(big) + (big ? D_BP : S_BP);
   endfunction

   function automatic int act_ln(bit big, bit s);
      if (big) return s ? D_AL6 : D_AL5;
      return s ? S_AL6 : S_AL5;
   endfunction

   function automatic int vs_beg(bit big, bit s);
      if (big) return s ? D_AL6 + D_G6 : D_AL5 + D_G5;
      return s ? S_AL6 + S_G6 : S_AL5 + S_G5;
   endfunction

   function automatic int vtot(bit big, bit s, bit il, int f);
      int p;
      if (big) p = s ? D_PR6 : D_PR5;
      else     p = s ? S_PR6 : S_PR5;
      return (il && f == 1) ? p + 1 : p;
   endfunction

   task automatic cmp(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (model h=%0d v=%0d f=%0d)",
                  tag, act, exp, mh, mv, mf);
      end
   endtask

   task automatic check_all(bit big, bit s);
      int eh, ev, ea;
      int vl;
      vl = big ? D_VL : S_VL;
      eh = !((mh >= act_pix(big) + fp_of(big, s)) &&
             (mh <  act_pix(big) + fp_of(big, s) + syn_pix(big)));
      ev = !((mv >= vs_beg(big, s)) && (mv < vs_beg(big, s) + vl));
      ea = (mh < act_pix(big)) && (mv < act_ln(big, s));
      if (big) begin
         cmp("R2 R3 h_cnt",   int'(h0), mh);
         cmp("R5 R6 v_cnt",   int'(v0), mv);
         cmp("R6 field",      int'(f0), mf);
         cmp("R4 hsync_n",    int'(hs0), eh);
         cmp("R7 vsync_n",    int'(vs0), ev);
         cmp("R8 active",     int'(ac0), ea);
      end else begin
         cmp("R2 R3 h_cnt",   int'(h1), mh);
         cmp("R5 R6 v_cnt",   int'(v1), mv);
         cmp("R6 field",      int'(f1), mf);
         cmp("R4 hsync_n",    int'(hs1), eh);
         cmp("R7 vsync_n",    int'(vs1), ev);
         cmp("R8 active",     int'(ac1), ea);
      end
   endtask

   task automatic model_step(bit big, bit s, bit il);
      if (mh >= htot(big, s) - 1) begin
         mh = 0;
         if (mv >= vtot(big, s, il, mf) - 1) begin
            mv = 0;
            mf = il ? 1 - mf : 0;
         end else begin
            mv = mv + 1;
         end
      end else begin
         mh = mh + 1;
      end
   endtask

   task automatic do_reset(bit s, bit il);
      @(negedge clk);
      rst_n = 1'b0;
      pix_en = 1'b0;
      sys_625 = s;
      interlace = il;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mh = 0; mv = 0; mf = 0;
   endtask

   task automatic check_reset();
      // R1
      cmp("R1 h_cnt",   int'(h0), 0);
      cmp("R1 v_cnt",   int'(v0), 0);
      cmp("R1 field",   int'(f0), 0);
      cmp("R1 hsync_n", int'(hs0), 1);
      cmp("R1 vsync_n", int'(vs0), 1);
      cmp("R1 active",  int'(ac0), 1);
      cmp("R1 h_cnt scaled", int'(h1), 0);
      cmp("R1 v_cnt scaled", int'(v1), 0);
   endtask

   task automatic run(bit big, bit s, bit gate, bit il, int n);
      for (int k = 0; k < n; k++) begin
         bit en;
         @(negedge clk);
         check_all(big, s);
         en = gate ? (k % 3 != 2) : 1'b1;
         pix_en = en;
         if (en) model_step(big, s, il);
      end
      @(negedge clk);
      check_all(big, s);
      pix_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset(1'b0, 1'b0);
      check_reset();

      // frame-level vectors on the scaled instance (R2 R3 R4 R5 R6 R7 R8)
      for (int i = 0; i < NVEC; i++) begin
         do_reset(VEC[i][18], VEC[i][17]);
         run(1'b0, VEC[i][18], VEC[i][16], VEC[i][17], int'(VEC[i][15:0]));
      end

      // R3 R4 R8: full 858-pixel lines at default geometry, interlaced
      do_reset(1'b0, 1'b1);
      run(1'b1, 1'b0, 1'b0, 1'b1, 3 * 858 + 5);

      // R3 R4 R8: full 864-pixel lines with a gated enable
      do_reset(1'b1, 1'b0);
      run(1'b1, 1'b1, 1'b1, 1'b0, 3 * 864 + 5);

      // R1: reset in the middle of a line returns to the reset state
      do_reset(1'b1, 1'b1);
      check_reset();

      // R2: a long idle stretch leaves everything unchanged
      run(1'b0, 1'b1, 1'b0, 1'b1, 45);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         pix_en = 1'b0;
         check_all(1'b0, 1'b1);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule